// File: doc/BRIEF.md
# Status Byte and Service Request Logic

This block assembles an eight-bit instrument status byte from summary information supplied by the rest of a remote-control subsystem. Those inputs are: a flag saying the error queue holds entries, a flag saying a reply message is waiting, an event status register with its enable mask, and event/enable pairs for the questionable and operation status registers. The block keeps a writable service request enable mask. From the status bits and that mask it computes a master summary bit.

A service request output is raised when a status bit that is enabled in the mask goes from 0 to 1. The request stays raised until a serial poll read acknowledges it. A host reads the status byte or the enable mask through a one-bit address and writes the mask through the same port. A separate serial-poll port presents the status byte and carries the acknowledge strobe. Command parsing, error queue storage, the output buffer and the bus handshake sit outside this block.

Top module: `svc_req_status`

## Requirements
- R1: Status bits 1 and 0 always read 0. Bit 2 equals `err_pending` and bit 4 equals `msg_ready`, in the same cycle.
- R2: Bit 3 is 1 exactly when some bit of `ques_evt` and the same bit of `ques_en` are both 1. Bit 7 follows the same rule for `oper_evt` and `oper_en`.
- R3: Bit 5 is 1 exactly when some bit of `esr_evt` and the same bit of `esr_en` are both 1.
- R4: Bit 6 is 1 exactly when some status bit other than bit 6 is 1 and its bit in the enable mask is also 1.
- R5: Bit 6 of the enable mask affects neither status bit 6 nor `srq`.
- R6: A host write with `host_addr`=1 stores `host_wdata` as the enable mask (all 8 bits) at the clock edge. From the next cycle, a read with `host_addr`=1 returns it. A host write with `host_addr`=0 changes nothing.
- R7: When `host_addr`=0, `host_rdata` equals the status byte. `poll_data` always equals the status byte.
- R8: If, at a clock edge, some enabled status bit (any bit except 6) is 1 and it was 0 at the previous edge, then `srq` is 1 after that edge.
- R9: `srq` stays 1 until an edge where `poll_rd`=1. At that edge it clears, unless a new enabled rising edge occurs at the same edge, in which case it stays 1.
- R10: Synchronous reset (`rst_n`=0) clears the enable mask, the edge history and `srq`.
- R11: A status bit held at 1 does not raise `srq` again after it has been acknowledged. Only a fresh 0-to-1 change does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_pending | input | 1 | Error queue holds at least one entry |
| msg_ready | input | 1 | Output buffer holds a readable message |
| esr_evt | input | ESR_W | Event status register contents |
| esr_en | input | ESR_W | Event status enable mask |
| ques_evt | input | QUES_W | Questionable event bits |
| ques_en | input | QUES_W | Questionable enable bits |
| oper_evt | input | OPER_W | Operation event bits |
| oper_en | input | OPER_W | Operation enable bits |
| host_addr | input | 1 | 0 selects the status byte, 1 selects the enable mask |
| host_wr | input | 1 | Write strobe for the enable mask |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Combinational read data for `host_addr` |
| poll_rd | input | 1 | Serial poll read strobe; acknowledges the request |
| poll_data | output | 8 | Status byte presented to the serial poll |
| srq | output | 1 | Service request |

## Verification
The status byte, including bit 6, is combinational, so it is due in the same cycle as the inputs or mask that produce it. A mask write shows in the read-back and in bit 6 from the cycle after its edge. `srq` changes one edge after the rising bit or the poll strobe is sampled. The bench drives inputs just after a rising edge, advances its reference model at the rising edge from the same sampled inputs, and compares every output at the falling edge, so every result is checked in the cycle it falls due.

// File: rtl/svc_status_pkg.sv
// Package: shared constants and types for the status byte block.
// Assumes an 8-bit status byte with fixed bit meanings.
package svc_status_pkg;
    localparam int SB_W      = 8;
    localparam int B_ERRQ    = 2;
    localparam int B_QUES    = 3;
    localparam int B_MSG     = 4;
    localparam int B_ESUM    = 5;
    localparam int B_MSS     = 6;
    localparam int B_OPER    = 7;
    // Bits that feed the summary and the edge detector (all but bit 6).
    localparam logic [SB_W-1:0] SRC_MASK = 8'hBF;

    typedef logic [SB_W-1:0] stat_byte_t;
endpackage

// File: rtl/masked_any.sv
// masked_any: reports whether any event bit is set together with its enable bit.
// Assumes evt and en are level signals of equal width W.
module masked_any #(
    parameter int W = 8
) (
    input  logic [W-1:0] evt,
    input  logic [W-1:0] en,
    output logic         any
);
    logic [W-1:0] hits;

    // Per-bit qualification of each event by its enable.
    for (genvar i = 0; i < W; i++) begin : g_hit
        assign hits[i] = evt[i] & en[i];
    end

    // Reduce qualified events to one summary flag.
    always_comb begin
        any = |hits;
    end
endmodule

// File: rtl/sre_reg.sv
// sre_reg: holds the service request enable mask written by the host.
// Assumes one write port; the mask is stored in full, bit 6 included.
module sre_reg
    import svc_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  stat_byte_t wdata,
    output stat_byte_t mask
);
    stat_byte_t mask_q;

    // Capture a host write; reset clears the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= wdata;
        end
    end

    assign mask = mask_q;
endmodule

// File: rtl/srq_edge.sv
// srq_edge: detects enabled 0-to-1 changes of status bits and latches a
// service request until a poll acknowledge. Bit 6 never takes part.
// Assumes ack is a single-cycle strobe sampled at the clock edge.
module srq_edge
    import svc_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  stat_byte_t sb,
    input  stat_byte_t en,
    input  logic       ack,
    output stat_byte_t rise,
    output logic       srq
);
    stat_byte_t hist_q;
    logic       srq_q;

    // Enabled bits that are set now but were clear at the previous edge.
    always_comb begin
        rise = sb & ~hist_q & en & SRC_MASK;
    end

    // Remember the status bits seen at each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= sb & SRC_MASK;
        end
    end

    // Set on a new enabled edge, clear on acknowledge; setting wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srq_q <= 1'b0;
        end else if (|rise) begin
            srq_q <= 1'b1;
        end else if (ack) begin
            srq_q <= 1'b0;
        end
    end

    assign srq = srq_q;
endmodule

// File: rtl/svc_req_status.sv
// svc_req_status: builds the status byte, the master summary bit and the
// service request, with a host read/write port and a serial poll port.
// Assumes all summary inputs are synchronous to clk.
module svc_req_status
    import svc_status_pkg::*;
#(
    parameter int ESR_W  = 8,
    parameter int QUES_W = 16,
    parameter int OPER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_pending,
    input  logic              msg_ready,
    input  logic [ESR_W-1:0]  esr_evt,
    input  logic [ESR_W-1:0]  esr_en,
    input  logic [QUES_W-1:0] ques_evt,
    input  logic [QUES_W-1:0] ques_en,
    input  logic [OPER_W-1:0] oper_evt,
    input  logic [OPER_W-1:0] oper_en,
    input  logic              host_addr,
    input  logic              host_wr,
    input  logic [SB_W-1:0]   host_wdata,
    output logic [SB_W-1:0]   host_rdata,
    input  logic              poll_rd,
    output logic [SB_W-1:0]   poll_data,
    output logic              srq
);
    logic       ques_any;
    logic       oper_any;
    logic       esr_any;
    stat_byte_t sre_q;
    stat_byte_t sb_raw;
    stat_byte_t sb;
    stat_byte_t rise_vec;

    masked_any #(.W(QUES_W)) u_ques (.evt(ques_evt), .en(ques_en), .any(ques_any));
    masked_any #(.W(OPER_W)) u_oper (.evt(oper_evt), .en(oper_en), .any(oper_any));
    masked_any #(.W(ESR_W))  u_esr  (.evt(esr_evt),  .en(esr_en),  .any(esr_any));

    sre_reg u_sre (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (host_wr & host_addr),
        .wdata (host_wdata),
        .mask  (sre_q)
    );

    // Place each summary source in its bit; bit 6 filled below.
    always_comb begin
        sb_raw         = '0;
        sb_raw[B_ERRQ] = err_pending;
        sb_raw[B_QUES] = ques_any;
        sb_raw[B_MSG]  = msg_ready;
        sb_raw[B_ESUM] = esr_any;
        sb_raw[B_OPER] = oper_any;
    end

    // Master summary: any enabled source bit, mask bit 6 excluded.
    always_comb begin
        sb        = sb_raw;
        sb[B_MSS] = |(sb_raw & sre_q & SRC_MASK);
    end

    srq_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sb    (sb),
        .en    (sre_q),
        .ack   (poll_rd),
        .rise  (rise_vec),
        .srq   (srq)
    );

    // Host read mux and poll data.
    always_comb begin
        host_rdata = host_addr ? sre_q : sb;
        poll_data  = sb;
    end
endmodule

// File: rtl/svc_req_status_chk.sv
// svc_req_status_chk: property checks for svc_req_status, bound into it.
// Assumes the bound signal names of the top module.
module svc_req_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] sb,
    input logic [7:0] sre,
    input logic [7:0] rise,
    input logic       srq,
    input logic       poll_rd,
    input logic       host_addr,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata
);
    a_r1_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sb[1:0] == 2'b00);

    a_r4_summary: assert property (@(posedge clk) disable iff (!rst_n)
        sb[6] == |(sb & sre & 8'hBF));

    a_r5_sre6_inert: assert property (@(posedge clk) disable iff (!rst_n)
        ((sre & 8'hBF) == 8'h00) |-> (!sb[6] && (rise == 8'h00)));

    a_r6_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr) |=> (sre == $past(host_wdata)));

    a_r7_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        !host_addr |-> (host_rdata == sb));

    a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> srq);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (srq && !poll_rd) |=> srq);

    a_r9_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (srq && poll_rd && !(|rise)) |=> !srq);

    a_r10_reset: assert property (@(posedge clk)
        !rst_n |=> (!srq && (sre == 8'h00)));
endmodule

bind svc_req_status svc_req_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sb         (sb),
    .sre        (sre_q),
    .rise       (rise_vec),
    .srq        (srq),
    .poll_rd    (poll_rd),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
);

// File: tb/svc_req_status_bench.sv
// Bench: behavioural reference model advanced at each rising edge and
// compared with every output at each falling edge.
module svc_req_status_bench;
    localparam int ESR_W  = 8;
    localparam int QUES_W = 16;
    localparam int OPER_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              err_pending = 1'b0;
    logic              msg_ready = 1'b0;
    logic [ESR_W-1:0]  esr_evt = '0;
    logic [ESR_W-1:0]  esr_en = '0;
    logic [QUES_W-1:0] ques_evt = '0;
    logic [QUES_W-1:0] ques_en = '0;
    logic [OPER_W-1:0] oper_evt = '0;
    logic [OPER_W-1:0] oper_en = '0;
    logic              host_addr = 1'b0;
    logic              host_wr = 1'b0;
    logic [7:0]        host_wdata = '0;
    logic [7:0]        host_rdata;
    logic              poll_rd = 1'b0;
    logic [7:0]        poll_data;
    logic              srq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Reference state.
    logic [7:0] m_mask = '0;
    logic [7:0] m_prev = '0;
    logic       m_srq  = 1'b0;

    svc_req_status #(.ESR_W(ESR_W), .QUES_W(QUES_W), .OPER_W(OPER_W)) u_svc_req_status (
        .clk(clk), .rst_n(rst_n), .err_pending(err_pending), .msg_ready(msg_ready),
        .esr_evt(esr_evt), .esr_en(esr_en), .ques_evt(ques_evt), .ques_en(ques_en),
        .oper_evt(oper_evt), .oper_en(oper_en), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .poll_rd(poll_rd),
        .poll_data(poll_data), .srq(srq)
    );

    always #2 clk = ~clk;

    function automatic bit any_pair(input logic [31:0] a, input logic [31:0] b, input int w);
        for (int i = 0; i < w; i++) if (a[i] && b[i]) return 1'b1;
        return 1'b0;
    endfunction

    // Expected status byte without bit 6.
    function automatic logic [7:0] exp_src();
        logic [7:0] v;
        v    = 8'h00;
        v[2] = err_pending;
        v[3] = any_pair(32'(ques_evt), 32'(ques_en), QUES_W);
        v[4] = msg_ready;
        v[5] = any_pair(32'(esr_evt), 32'(esr_en), ESR_W);
        v[7] = any_pair(32'(oper_evt), 32'(oper_en), OPER_W);
        return v;
    endfunction

    function automatic logic [7:0] exp_sb();
        logic [7:0] v;
        v = exp_src();
        v[6] = 1'b0;
        for (int i = 0; i < 8; i++) if (i != 6 && v[i] && m_mask[i]) v[6] = 1'b1;
        return v;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model update at the rising edge.
    always @(posedge clk) begin
        logic [7:0] src;
        logic       rose;
        src  = exp_src();
        rose = 1'b0;
        if (!rst_n) begin
            m_mask = '0; m_prev = '0; m_srq = 1'b0;
        end else begin
            for (int i = 0; i < 8; i++)
                if (i != 6 && src[i] && !m_prev[i] && m_mask[i]) rose = 1'b1;
            if (rose) m_srq = 1'b1;
            else if (poll_rd) m_srq = 1'b0;
            m_prev = src;
            if (host_wr && host_addr) m_mask = host_wdata;
        end
    end

    // Compare every output at the falling edge.
    always @(negedge clk) begin
        logic [7:0] e;
        if (!done) begin
            e = exp_sb();
            if (!rst_n) begin
                check("R10 srq in reset", int'(srq), int'(m_srq));
            end else begin
                check("R1 low bits", int'(poll_data[1:0]), 0);
                check("R1 error bit", int'(poll_data[2]), int'(e[2]));
                check("R1 message bit", int'(poll_data[4]), int'(e[4]));
                check("R2 questionable bit", int'(poll_data[3]), int'(e[3]));
                check("R2 operation bit", int'(poll_data[7]), int'(e[7]));
                check("R3 event summary bit", int'(poll_data[5]), int'(e[5]));
                check("R4 master summary", int'(poll_data[6]), int'(e[6]));
                check("R7 poll data", int'(poll_data), int'(e));
                if (!host_addr) check("R7 host status read", int'(host_rdata), int'(e));
                else            check("R6 mask readback", int'(host_rdata), int'(m_mask));
                check("R8 R9 srq", int'(srq), int'(m_srq));
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic clear_strobes();
        host_wr = 1'b0; poll_rd = 1'b0;
    endtask

    task automatic write_mask(input logic [7:0] v);
        host_addr = 1'b1; host_wr = 1'b1; host_wdata = v;
        step(); clear_strobes();
    endtask

    task automatic poll();
        poll_rd = 1'b1; step(); poll_rd = 1'b0;
    endtask

    initial begin
        #1;
        repeat (4) step();
        check("R10 mask after reset", int'(u_svc_req_status.host_rdata), int'(host_addr ? 8'h00 : exp_sb()));
        rst_n = 1'b1;
        host_addr = 1'b1; step();
        check("R10 mask cleared", int'(host_rdata), 0);
        check("R10 no request", int'(srq), 0);

        // R6: a write with address 0 is ignored.
        host_addr = 1'b0; host_wr = 1'b1; host_wdata = 8'hFF; step(); clear_strobes();
        host_addr = 1'b1; #0;
        check("R6 ignored write", int'(host_rdata), 0);

        // R5: only mask bit 6 set; no summary and no request.
        write_mask(8'h40);
        err_pending = 1'b1; msg_ready = 1'b1; esr_evt = 8'hFF; esr_en = 8'hFF;
        ques_evt = '1; ques_en = '1; oper_evt = '1; oper_en = '1;
        step(); step();
        check("R5 summary unaffected", int'(poll_data[6]), 0);
        check("R5 no request", int'(srq), 0);
        err_pending = 1'b0; msg_ready = 1'b0; esr_evt = '0; ques_evt = '0; oper_evt = '0;
        step();

        // R8: enabled error bit rises, request one edge later.
        write_mask(8'h04);
        err_pending = 1'b1; #0;
        check("R8 not yet", int'(srq), 0);
        step();
        check("R8 raised", int'(srq), 1);
        step(); step();
        check("R9 held", int'(srq), 1);
        poll();
        check("R9 acknowledged", int'(srq), 0);
        // R11: level held high raises no new request.
        repeat (5) step();
        check("R11 no re-raise", int'(srq), 0);
        err_pending = 1'b0; step();
        err_pending = 1'b1; step();
        check("R11 fresh edge", int'(srq), 1);
        poll();
        err_pending = 1'b0;

        // R9: acknowledge coincides with a new rising edge.
        write_mask(8'h14);
        msg_ready = 1'b0; err_pending = 1'b1; step();
        check("R9 set before", int'(srq), 1);
        msg_ready = 1'b1; poll();
        check("R9 set wins", int'(srq), 1);
        poll();
        check("R9 cleared", int'(srq), 0);
        msg_ready = 1'b0; err_pending = 1'b0; step();

        // Randomised traffic, compared every cycle by the monitor.
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(7) == 0) err_pending = ~err_pending;
            if ($urandom_range(7) == 0) msg_ready = ~msg_ready;
            if ($urandom_range(3) == 0) esr_evt = ESR_W'($urandom);
            if ($urandom_range(15) == 0) esr_en = ESR_W'($urandom);
            if ($urandom_range(3) == 0) ques_evt = QUES_W'($urandom & $urandom);
            if ($urandom_range(15) == 0) ques_en = QUES_W'($urandom);
            if ($urandom_range(3) == 0) oper_evt = OPER_W'($urandom & $urandom);
            if ($urandom_range(15) == 0) oper_en = OPER_W'($urandom);
            host_addr  = 1'($urandom);
            host_wr    = ($urandom_range(7) == 0);
            host_wdata = 8'($urandom);
            poll_rd    = ($urandom_range(5) == 0);
            if (n == 2000) rst_n = 1'b0;
            if (n == 2003) rst_n = 1'b1;
            step();
        end
        clear_strobes();
        step();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule